// File: doc/BRIEF.md
# Product-Term AND Array

This block is the sum-of-products front end of a small programmable-logic model. It receives twenty logic signals and expands each of them into a true column and a complemented column, giving forty array columns. Sixty-four product-term rows each form the AND of whichever columns their stored connection bits select. The rows come out as eight bundles of eight terms, one bundle for each downstream output cell. That cell ORs the bundle or uses part of it in another way.

The connection bits are held in a row-organised configuration store. A write strobe, a row address and a forty-bit data word load one row per clock. The same address reads a row back combinationally. Term evaluation is purely combinational from the signals and the stored bits. The first term of every bundle is also brought out on its own, so that an output cell can use it as a per-output enable instead of a data term.

Top module: `pla_and_array`

## Requirements
- R1: Column 2*i of the array carries `sig_in[i]` and column 2*i+1 carries its complement. Bit c of a row's connection word connects column c to that row.
- R2: Each term equals the AND of all columns its row connects, evaluated from the current `sig_in` and the stored connection bits.
- R3: A row whose connection word is all zeros produces a HIGH term for every input pattern.
- R4: A row that connects both column 2*i and column 2*i+1 for any i produces a LOW term for every input pattern.
- R5: `term_bus[8*g+k]` is term k of group g and is driven by row 8*g+k, for groups 0 to 7 and positions 0 to 7.
- R6: `oe_term[g]` carries the term of row 8*g, the first term of group g.
- R7: When `cfg_we` is high at a rising clock edge, row `cfg_addr` takes `cfg_wdata` and every other row keeps its value.
- R8: `cfg_rdata` shows the stored word of row `cfg_addr` without waiting for a clock edge.
- R9: While `rst_n` is low, every row is cleared to zero. After reset every term and every enable term is HIGH and every row reads back as zero.
- R10: A change on `sig_in` reaches `term_bus` and `oe_term` within the same clock period, with no clock edge in between.
- R11: With `cfg_we` low, clock edges leave every stored row unchanged, whatever `cfg_addr` and `cfg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset, clears all rows |
| sig_in | input | 20 | Logic signals feeding the array |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 6 | Row address for write and readback |
| cfg_wdata | input | 40 | Connection word to store |
| cfg_rdata | output | 40 | Connection word of the addressed row |
| term_bus | output | 64 | All terms, group g at bits 8*g+7 down to 8*g |
| oe_term | output | 8 | First term of each group, for output enable |

## Verification
From the ports, the hardest case is telling a contradicted row apart from an empty one. It is also hard to prove that an enable term follows its own row and no neighbour in the same bundle. Both need specific words written into specific rows before any signal pattern means anything. The stimulus therefore writes several rows by hand: an enable row with both polarities of one signal, an enable row with a single column, a row of all complements, and a row mixing true and complement columns. It then steps `sig_in` between clock edges to show the combinational path. After that, a long random phase of sparse writes and signal changes is compared every cycle against a behavioural model.

// File: rtl/pla_pkg.sv
package pla_pkg;
    // Shape of the array
    localparam int unsigned NUM_SIGS   = 20;
    localparam int unsigned NUM_COLS   = 2 * NUM_SIGS;
    localparam int unsigned NUM_ROWS   = 64;
    localparam int unsigned GROUP_SIZE = 8;
    localparam int unsigned NUM_GROUPS = NUM_ROWS / GROUP_SIZE;
    localparam int unsigned ADDR_W     = $clog2(NUM_ROWS);
    // Position of the enable tap inside each group
    localparam int unsigned OE_POS     = 0;
endpackage

// File: rtl/pla_col_drive.sv
module pla_col_drive #(
    parameter int unsigned NSIG = pla_pkg::NUM_SIGS,
    localparam int unsigned NCOL = 2 * NSIG
) (
    input  logic [NSIG-1:0] sig_i,
    output logic [NCOL-1:0] cols_o
);
    // Even column: true form; odd column: complement
    for (genvar i = 0; i < NSIG; i++) begin : g_pair
        assign cols_o[2*i]   = sig_i[i];
        assign cols_o[2*i+1] = ~sig_i[i];
    end
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int unsigned ROWS = pla_pkg::NUM_ROWS,
    parameter int unsigned COLS = pla_pkg::NUM_COLS,
    parameter int unsigned AW   = pla_pkg::ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [COLS-1:0]           wdata_i,
    output logic [COLS-1:0]           rdata_o,
    output logic [ROWS-1:0][COLS-1:0] conn_o
);
    logic [ROWS-1:0][COLS-1:0] mem_q;
    logic                      addr_ok;

    assign addr_ok = (32'(addr_i) < ROWS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we_i && addr_ok) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = addr_ok ? mem_q[addr_i] : '0;
    assign conn_o  = mem_q;

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o == $past(wdata_i)) || (addr_i != $past(addr_i)));

    // R11
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_q));
endmodule

// File: rtl/pla_term_row.sv
module pla_term_row #(
    parameter int unsigned COLS = pla_pkg::NUM_COLS
) (
    input  logic [COLS-1:0] conn_i,
    input  logic [COLS-1:0] cols_i,
    output logic            term_o
);
    // A connected column that is LOW pulls the term LOW.
    // No connection leaves the term HIGH.
    always_comb begin
        term_o = 1'b1;
        for (int c = 0; c < int'(COLS); c++) begin
            if (conn_i[c] && !cols_i[c]) begin
                term_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pla_group_tap.sv
module pla_group_tap #(
    parameter int unsigned ROWS   = pla_pkg::NUM_ROWS,
    parameter int unsigned GSIZE  = pla_pkg::GROUP_SIZE,
    parameter int unsigned OE_IDX = pla_pkg::OE_POS,
    localparam int unsigned NGRP  = ROWS / GSIZE
) (
    input  logic [ROWS-1:0] terms_i,
    output logic [ROWS-1:0] bus_o,
    output logic [NGRP-1:0] oe_o
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // Bundle g occupies rows GSIZE*g .. GSIZE*g+GSIZE-1
        assign bus_o[g*GSIZE +: GSIZE] = terms_i[g*GSIZE +: GSIZE];
        assign oe_o[g]                 = terms_i[g*GSIZE + OE_IDX];
    end
endmodule

// File: rtl/pla_and_array.sv
module pla_and_array #(
    parameter int unsigned NSIG   = pla_pkg::NUM_SIGS,
    parameter int unsigned ROWS   = pla_pkg::NUM_ROWS,
    parameter int unsigned GSIZE  = pla_pkg::GROUP_SIZE,
    parameter int unsigned OE_IDX = pla_pkg::OE_POS,
    localparam int unsigned COLS  = 2 * NSIG,
    localparam int unsigned NGRP  = ROWS / GSIZE,
    localparam int unsigned AW    = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] sig_in,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [COLS-1:0] cfg_wdata,
    output logic [COLS-1:0] cfg_rdata,
    output logic [ROWS-1:0] term_bus,
    output logic [NGRP-1:0] oe_term
);
    logic [COLS-1:0]           cols;
    logic [ROWS-1:0][COLS-1:0] conn;
    logic [ROWS-1:0]           terms;

    pla_col_drive #(.NSIG(NSIG)) u_cols (
        .sig_i  (sig_in),
        .cols_o (cols)
    );

    pla_cfg_store #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .conn_o  (conn)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        pla_term_row #(.COLS(COLS)) u_row (
            .conn_i (conn[r]),
            .cols_i (cols),
            .term_o (terms[r])
        );

        // Row connects both polarities of some signal
        logic contra;
        always_comb begin
            contra = 1'b0;
            for (int i = 0; i < int'(NSIG); i++) begin
                if (conn[r][2*i] && conn[r][2*i+1]) begin
                    contra = 1'b1;
                end
            end
        end

        // R3
        empty_row_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conn[r] == '0) |-> term_bus[r]);

        // R4
        both_pol_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            contra |-> !term_bus[r]);
    end

    pla_group_tap #(.ROWS(ROWS), .GSIZE(GSIZE), .OE_IDX(OE_IDX)) u_tap (
        .terms_i (terms),
        .bus_o   (term_bus),
        .oe_o    (oe_term)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_oe_chk
        // R6
        oe_empty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conn[g*GSIZE + OE_IDX] == '0) |-> oe_term[g]);
    end
endmodule

// File: tb/pla_and_array_bench.sv
module pla_and_array_bench;
    localparam int NS = 20;
    localparam int NC = 40;
    localparam int NR = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sig_in = '0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_addr = '0;
    logic [NC-1:0] cfg_wdata = '0;
    logic [NC-1:0] cfg_rdata;
    logic [NR-1:0] term_bus;
    logic [7:0]    oe_term;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    bit  cmp_on  = 0;

    bit [NC-1:0] model_mem [NR];

    always #10 clk = ~clk;

    pla_and_array u_pla_and_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .term_bus  (term_bus),
        .oe_term   (oe_term)
    );

    // Behavioural model of the configuration store
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) model_mem[r] = '0;
        end else if (cfg_we) begin
            model_mem[cfg_addr] = cfg_wdata;
        end
    end

    // Expected term: walk signal by signal
    function automatic bit model_term(int r);
        for (int i = 0; i < NS; i++) begin
            if (model_mem[r][2*i]   && !sig_in[i]) return 1'b0;
            if (model_mem[r][2*i+1] &&  sig_in[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            logic [NR-1:0] exp_bus;
            logic [7:0]    exp_oe;
            for (int r = 0; r < NR; r++) exp_bus[r] = model_term(r);
            for (int g = 0; g < 8; g++) exp_oe[g] = model_term(8*g);
            check("R2/R5 term_bus", 64'(term_bus), 64'(exp_bus));
            check("R6 oe_term", 64'(oe_term), 64'(exp_oe));
            check("R8 cfg_rdata", 64'(cfg_rdata), 64'(model_mem[cfg_addr]));
        end
    end

    task automatic write_row(int a, logic [NC-1:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic set_sig(logic [NS-1:0] v);
        sig_in = v; #1;
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R9 terms in reset", 64'(term_bus), {64{1'b1}});
        check("R9 oe in reset", 64'(oe_term), 64'hFF);
        check("R9 readback in reset", 64'(cfg_rdata), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        set_sig(20'hABCDE);
        check("R3/R9 empty rows high after reset", 64'(term_bus), {64{1'b1}});
        cmp_on = 1;

        // R4: row 0 connects both polarities of signal 4 (bits 8 and 9)
        write_row(0, 40'h300);
        set_sig(20'h00010);
        check("R4 contra row low, sig4=1", 64'(term_bus[0]), 64'd0);
        set_sig(20'h00000);
        check("R4 contra row low, sig4=0", 64'(term_bus[0]), 64'd0);
        check("R6 oe group0 follows row0", 64'(oe_term[0]), 64'd0);

        // R1/R6: row 8 connects true column of signal 0 (bit 0)
        write_row(8, 40'h1);
        set_sig(20'h00001);
        check("R1 true column, sig0=1", 64'(oe_term[1]), 64'd1);
        set_sig(20'h00000);
        check("R1 true column, sig0=0", 64'(oe_term[1]), 64'd0);

        // R1: row 63 connects every complement column (odd bits)
        write_row(63, 40'hAAAAAAAAAA);
        check("R1 all complements, sig=0", 64'(term_bus[63]), 64'd1);
        set_sig(20'h80000);
        check("R1 all complements, sig19=1", 64'(term_bus[63]), 64'd0);
        check("R5 group7 pos7 only", 64'(term_bus[62]), 64'd1);

        // R2: row 5 = true sig3 (bit 6) and complement sig7 (bit 15)
        write_row(5, 40'h8040);
        set_sig(20'h00008);
        check("R2 sig3=1 sig7=0", 64'(term_bus[5]), 64'd1);
        // R10: change between edges, no clock in between
        set_sig(20'h00088);
        check("R10 same-period response", 64'(term_bus[5]), 64'd0);
        set_sig(20'h00000);
        check("R2 sig3=0", 64'(term_bus[5]), 64'd0);

        // R7 / R8 readback of written and neighbour rows
        cfg_addr = 6'd5; #1;
        check("R8 readback row5", 64'(cfg_rdata), 64'h8040);
        cfg_addr = 6'd4; #1;
        check("R7 neighbour row4 untouched", 64'(cfg_rdata), 64'd0);

        // R11: strobe low with busy address and data
        @(posedge clk); #2;
        cfg_addr = 6'd5; cfg_wdata = 40'hFFFFFFFFFF;
        @(posedge clk); #2;
        cfg_addr = 6'd4; cfg_wdata = 40'h123456789A;
        @(posedge clk); #2;
        cfg_addr = 6'd5; #1;
        check("R11 row5 held without strobe", 64'(cfg_rdata), 64'h8040);
        cfg_addr = 6'd4; #1;
        check("R11 row4 held without strobe", 64'(cfg_rdata), 64'd0);

        // Random phase, compared every cycle
        for (int n = 0; n < 600; n++) begin
            @(posedge clk); #2;
            cfg_we   = ($urandom_range(0, 3) == 0);
            cfg_addr = 6'($urandom_range(0, NR - 1));
            cfg_wdata = ($urandom_range(0, 4) == 0) ? '0 :
                        40'({$urandom, $urandom} & {$urandom, $urandom} &
                            {$urandom, $urandom} & {$urandom, $urandom});
            sig_in = 20'($urandom);
        end
        @(posedge clk); #2;
        cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule